// File: doc/BRIEF.md
# Pin-Addressed I2C Control/Status Target

This block is an I2C target for a power-output controller. It watches the serial clock and data lines, oversampling them in the system clock domain, and drives the data line only as an open-drain pull-down. The 7-bit address it answers to is a fixed upper part with two low bits taken from a 2-bit select input, so four copies can share one bus.

A master writes a one-byte control register. Its low three bits pick one of eight output levels and bit 3 switches the output on. A master reads a one-byte status value that the neighbouring fault logic presents on `status_in`. Both registers sit at internal address 0x00 and are told apart only by the direction bit. When a read address is acknowledged, the block pulses a strobe so that the fault logic can clear its latched flags. While the supply-undervoltage flag is raised, the block acknowledges nothing.

Top module: `pwrctl_i2c_target`

## Requirements
- R1: The block acknowledges (pulls SDA low during the 9th clock) an address byte only when its upper 7 bits equal 0b00010 followed by `addr_sel[1:0]`. This makes the write bytes 0x10/0x12/0x14/0x16 and the read bytes 0x11/0x13/0x15/0x17.
- R2: A write transfer (address with bit0=0, register byte 0x00, data byte) has every byte acknowledged and loads `lvl_code` from data bits 2:0 and `out_on` from data bit 3. Data bits 7:4 have no effect.
- R3: A data byte written after a register byte other than 0x00 is acknowledged but leaves `lvl_code` and `out_on` unchanged.
- R4: After reset, `sda_oe` is 0, `lvl_code` is 0 and `out_on` is 0.
- R5: After an acknowledged read address (bit0=1), the block returns, MSB first, the value of `status_in` sampled at the rising SCL edge of the address byte's 9th clock. Later changes of `status_in` are not seen in that transfer.
- R6: While the master acknowledges, each further byte repeats the same captured value. After a master NACK the block releases SDA until the next START or STOP.
- R7: While `undervolt` is 1, no byte is acknowledged and the control register is not written.
- R8: `rd_strobe` is a single-cycle pulse, issued once for each acknowledged read address and never for writes or for addresses that do not match.
- R9: `sda_oe` changes only while SCL is low. A START (SDA falling with SCL high) at any point restarts address reception, and a STOP (SDA rising with SCL high) returns the block to idle.
- R10: After an address that does not match, the block acknowledges none of the following bytes of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line (wired bus level) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 2 | Low two bits of the 7-bit target address |
| undervolt | input | 1 | Supply undervoltage flag; blocks all acknowledges |
| status_in | input | 8 | Status byte from the fault logic |
| lvl_code | output | 3 | Output level select from the control register |
| out_on | output | 1 | Output enable from the control register |
| rd_strobe | output | 1 | One-cycle pulse when a read address is acknowledged |

## Verification
A wrong bit counter or phase shows up at the ports within one byte time. The acknowledge moves off the 9th clock, or the returned status bits shift by a position, both of which the master sees on the next SCL rise. A wrong register-pointer decision or a missing undervoltage gate is seen at `lvl_code`/`out_on` right after the data byte's 8th clock falls. A snapshot taken at the wrong edge is caught by changing `status_in` just after the read address is acknowledged: the next byte then carries the new value.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_REG,
    PH_WDATA,
    PH_READ,
    PH_SKIP
  } phase_e;

  // 7-bit address compare: fixed base with the select bits placed at the bottom
  function automatic logic addr_hit(input logic [6:0] rx,
                                    input logic [6:0] base,
                                    input logic [1:0] sel);
    return rx == (base | {5'b00000, sel});
  endfunction

  // Whether the target may acknowledge the byte just received
  function automatic logic ack_allowed(input phase_e ph,
                                       input logic hit,
                                       input logic uv);
    return ((ph != PH_ADDR) || hit) && !uv;
  endfunction

  // Bit index driven during the low phase after rise number cnt of a sent byte
  function automatic logic [2:0] tx_index(input logic [3:0] cnt);
    return 3'(4'd7 - cnt);
  endfunction

endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else if (g == 0) begin
          scl_ff[g] <= scl_raw;
          sda_ff[g] <= sda_raw;
        end else begin
          scl_ff[g] <= scl_ff[(g == 0) ? 0 : g - 1];
          sda_ff[g] <= sda_ff[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_ff[LAST];
      sda_q <= sda_ff[LAST];
    end
  end

  assign scl_s     = scl_ff[LAST];
  assign sda_s     = sda_ff[LAST];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2ct_ctl_reg.sv
module i2ct_ctl_reg #(
  parameter int LVL_W = 3,
  localparam int CTL_W = LVL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic [LVL_W-1:0] lvl_code,
  output logic             out_on
);
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (wr_en) ctl_q <= wr_data;
  end

  assign lvl_code = ctl_q[LVL_W-1:0];
  assign out_on   = ctl_q[LVL_W];

  // R3: register contents move only on a committed write
  p_ctl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(ctl_q) |-> $past(wr_en));

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'h08,
  parameter int         SEL_W     = 2,
  parameter int         CTL_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic [SEL_W-1:0] addr_sel,
  input  logic             undervolt,
  input  logic [7:0]       status_in,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [CTL_W-1:0] wr_data,
  output logic             rd_strobe
);
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_CLK  = 4'd9;

  phase_e     phase;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic [7:0] snap;
  logic       ptr_zero;
  logic       ack_drv;

  // named events for the checks
  logic hit, byte_end, ack_end, may_ack;
  assign hit      = addr_hit(shreg[7:1], ADDR_BASE, addr_sel);
  assign byte_end = scl_fall && (cnt == LAST_BIT);
  assign ack_end  = scl_fall && (cnt == ACK_CLK);
  assign may_ack  = ack_allowed(phase, hit, undervolt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      snap      <= '0;
      ptr_zero  <= 1'b0;
      ack_drv   <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      rd_strobe <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      rd_strobe <= 1'b0;
      if (bus_stop) begin
        phase   <= PH_IDLE;
        sda_oe  <= 1'b0;
        ack_drv <= 1'b0;
      end else if (bus_start) begin
        phase   <= PH_ADDR;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        ack_drv <= 1'b0;
      end else if (scl_rise) begin
        case (phase)
          PH_ADDR, PH_REG, PH_WDATA: begin
            if (cnt < LAST_BIT) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (cnt == LAST_BIT) begin
              cnt <= ACK_CLK;
              if (phase == PH_ADDR && ack_drv && shreg[0]) begin
                snap      <= status_in;
                rd_strobe <= 1'b1;
              end
            end
          end
          PH_READ: begin
            if (cnt < LAST_BIT) cnt <= cnt + 4'd1;
            else if (cnt == LAST_BIT) begin
              if (sda_s) phase <= PH_SKIP;
              else       cnt   <= ACK_CLK;
            end
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        case (phase)
          PH_ADDR, PH_REG, PH_WDATA: begin
            if (cnt == LAST_BIT) begin
              if (may_ack) begin
                sda_oe  <= 1'b1;
                ack_drv <= 1'b1;
                if (phase == PH_REG) ptr_zero <= (shreg == 8'h00);
                if (phase == PH_WDATA && ptr_zero) begin
                  wr_en   <= 1'b1;
                  wr_data <= shreg[CTL_W-1:0];
                end
              end else begin
                phase <= PH_SKIP;
              end
            end else if (cnt == ACK_CLK) begin
              ack_drv <= 1'b0;
              cnt     <= '0;
              if (phase == PH_ADDR && shreg[0]) begin
                phase  <= PH_READ;
                sda_oe <= ~snap[7];
              end else begin
                sda_oe <= 1'b0;
                phase  <= (phase == PH_ADDR) ? PH_REG : PH_WDATA;
              end
            end
          end
          PH_READ: begin
            if (cnt == ACK_CLK) begin
              cnt    <= '0;
              sda_oe <= ~snap[7];
            end else if (cnt == LAST_BIT) begin
              sda_oe <= 1'b0;
            end else if (cnt != 4'd0) begin
              sda_oe <= ~snap[tx_index(cnt)];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: the data line is only moved while the clock is low
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_oe) |-> !scl_s);

  // R7: no acknowledge begins on a cycle that saw the undervoltage flag
  p_no_ack_uv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drv) |-> !$past(undervolt));

  // R8: the read strobe lasts one cycle
  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rd_strobe);

  // R8: the read strobe only accompanies a driven acknowledge
  p_strobe_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> sda_oe);

  // R10: nothing is driven while a non-matching transfer is skipped
  p_skip_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) && $past(phase == PH_SKIP) |-> !sda_oe);

endmodule

// File: rtl/pwrctl_i2c_target.sv
module pwrctl_i2c_target #(
  parameter logic [6:0] ADDR_BASE   = 7'h08,
  parameter int         SYNC_STAGES = 2,
  parameter int         LVL_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  input  logic [1:0]       addr_sel,
  input  logic             undervolt,
  input  logic [7:0]       status_in,
  output logic [LVL_W-1:0] lvl_code,
  output logic             out_on,
  output logic             rd_strobe
);
  localparam int CTL_W = LVL_W + 1;

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic wr_en;
  logic [CTL_W-1:0] wr_data;

  i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2ct_engine #(.ADDR_BASE(ADDR_BASE), .SEL_W(2), .CTL_W(CTL_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .addr_sel(addr_sel), .undervolt(undervolt), .status_in(status_in),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_data(wr_data), .rd_strobe(rd_strobe)
  );

  i2ct_ctl_reg #(.LVL_W(LVL_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .lvl_code(lvl_code), .out_on(out_on)
  );

endmodule

// File: tb/tb_pwrctl_i2c_target.sv
`timescale 1ns/1ps
module tb_pwrctl_i2c_target;
  localparam int H = 16;   // SCL half period in system clocks

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic [1:0] addr_sel = 2'b01;
  logic undervolt = 0;
  logic [7:0] status_in = 8'hA5;
  logic sda_oe, out_on, rd_strobe;
  logic [2:0] lvl_code;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  pwrctl_i2c_target dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .addr_sel(addr_sel), .undervolt(undervolt),
    .status_in(status_in), .lvl_code(lvl_code), .out_on(out_on),
    .rd_strobe(rd_strobe)
  );

  always #2 clk = ~clk;

  // scoreboard
  string tag_q[$];
  int    exp_q[$];
  int    act_q[$];
  int    checks = 0, fails = 0;
  int    strobes = 0, oe_bad = 0;
  bit    done = 0;

  task automatic expect_item(string tag, int exp, int act);
    tag_q.push_back(tag);
    exp_q.push_back(exp);
    act_q.push_back(act);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        string t; int e; int a;
        t = tag_q.pop_front(); e = exp_q.pop_front(); a = act_q.pop_front();
        checks++;
        if (a != e) begin
          fails++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
        end
      end
    end
  end

  logic oe_prev = 0;
  always @(posedge clk) begin
    if (rd_strobe) strobes++;
    if (rst_n && sda_oe != oe_prev && scl_m) oe_bad++;
    oe_prev <= sda_oe;
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1; wait_clk(H);
    scl_m = 1; wait_clk(H);
    sda_m = 0; wait_clk(H);
    scl_m = 0; wait_clk(2);
  endtask

  task automatic bus_stop;
    sda_m = 0; wait_clk(H);
    scl_m = 1; wait_clk(H);
    sda_m = 1; wait_clk(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_clk(H);
      scl_m = 1; wait_clk(H);
      scl_m = 0; wait_clk(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output int ack);
    send_bits(b, 8);
    sda_m = 1; wait_clk(H);
    scl_m = 1; wait_clk(H/2);
    ack = sda_line ? 0 : 1;
    wait_clk(H/2);
    scl_m = 0; wait_clk(2);
  endtask

  task automatic recv_byte(input bit mack, output int b);
    logic [7:0] v;
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(H);
      scl_m = 1; wait_clk(H/2);
      v[i] = sda_line;
      wait_clk(H/2);
      scl_m = 0;
    end
    wait_clk(2);
    sda_m = mack ? 1'b0 : 1'b1;
    wait_clk(H);
    scl_m = 1; wait_clk(H);
    scl_m = 0; wait_clk(2);
    sda_m = 1;
    b = int'(v);
  endtask

  task automatic ctl_write(input logic [7:0] a, input logic [7:0] r,
                           input logic [7:0] d, string tag);
    int k;
    bus_start;
    send_byte(a, k); expect_item({tag, " addr ack"}, 1, k);
    send_byte(r, k); expect_item({tag, " reg ack"}, 1, k);
    send_byte(d, k); expect_item({tag, " data ack"}, 1, k);
    bus_stop;
  endtask

  initial begin : stim
    int k, b;
    wait_clk(5); rst_n = 1; wait_clk(5);
    // R4 reset values
    expect_item("R4 sda_oe", 0, int'(sda_oe));
    expect_item("R4 control", 0, int'({out_on, lvl_code}));

    // R2 write with upper data bits set (0xFD -> level 5, on)
    ctl_write(8'h12, 8'h00, 8'hFD, "R2");
    expect_item("R2 control after write", 'hD, int'({out_on, lvl_code}));

    // R1/R10 wrong select bits: no ack for any byte
    bus_start;
    send_byte(8'h10, k); expect_item("R1 mismatched addr nack", 0, k);
    send_byte(8'h00, k); expect_item("R10 reg byte nack", 0, k);
    send_byte(8'h07, k); expect_item("R10 data byte nack", 0, k);
    bus_stop;
    expect_item("R10 control unchanged", 'hD, int'({out_on, lvl_code}));

    // R3 register address other than 0x00
    ctl_write(8'h12, 8'h05, 8'h02, "R3");
    expect_item("R3 control unchanged", 'hD, int'({out_on, lvl_code}));

    // R5/R6 read with repeated START
    status_in = 8'hA5;
    bus_start;
    send_byte(8'h12, k); expect_item("R5 addr ack", 1, k);
    send_byte(8'h00, k); expect_item("R5 reg ack", 1, k);
    bus_start;
    send_byte(8'h13, k); expect_item("R5 read addr ack", 1, k);
    status_in = 8'h3C;
    recv_byte(1, b); expect_item("R5 snapshot byte", 'hA5, b);
    recv_byte(0, b); expect_item("R6 repeated byte", 'hA5, b);
    recv_byte(0, b); expect_item("R6 released after nack", 'hFF, b);
    bus_stop;
    expect_item("R8 one strobe per read", 1, strobes);

    // R7 undervoltage
    undervolt = 1;
    bus_start;
    send_byte(8'h12, k); expect_item("R7 write addr nack", 0, k);
    bus_stop;
    bus_start;
    send_byte(8'h13, k); expect_item("R7 read addr nack", 0, k);
    bus_stop;
    undervolt = 0;
    bus_start;
    send_byte(8'h12, k); expect_item("R7 addr ack before flag", 1, k);
    undervolt = 1;
    send_byte(8'h00, k); expect_item("R7 reg nack under flag", 0, k);
    send_byte(8'h01, k); expect_item("R7 data nack under flag", 0, k);
    bus_stop;
    undervolt = 0;
    expect_item("R7 control unchanged", 'hD, int'({out_on, lvl_code}));
    expect_item("R8 no strobe for blocked read", 1, strobes);

    // R9 START in the middle of a byte restarts reception
    bus_start;
    send_bits(8'h55, 4);
    ctl_write(8'h12, 8'h00, 8'h0A, "R9");
    expect_item("R9 control after restart", 'hA, int'({out_on, lvl_code}));

    // R1 other select value
    addr_sel = 2'b11;
    bus_start;
    send_byte(8'h12, k); expect_item("R1 old address now nack", 0, k);
    bus_stop;
    ctl_write(8'h16, 8'h00, 8'h03, "R1");
    expect_item("R1 control via 0x16", 'h3, int'({out_on, lvl_code}));

    // R5 direct read without register byte
    status_in = 8'h5A;
    bus_start;
    send_byte(8'h17, k); expect_item("R5 read 0x17 ack", 1, k);
    recv_byte(0, b); expect_item("R5 status 0x5A", 'h5A, b);
    bus_stop;
    expect_item("R8 strobe count", 2, strobes);
    expect_item("R9 sda_oe moved while SCL high", 0, oe_bad);

    wait_clk(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule